// File: doc/BRIEF.md
# Microcoded Quad-Line Serial Flash Sequencer

This block runs one short microprogram per transaction on a serial flash bus that has a clock, an active-low select and four data lines. A trigger word names a sequence and gives a data byte count. The sequencer presents the sequence number on a table port and copies the four 32-bit words that come back into local storage. It then steps through up to eight 16-bit instructions. Each instruction picks its own phase (command byte, address byte, mode byte, idle clocks, read data or write data), its own line count (1, 2 or 4) and an 8-bit operand.

Write bytes are pulled from a transmit byte stream. Read bytes are pushed to a receive byte stream. When the program ends, a sticky completion flag is set. Software clears the flag by writing 1. The flag can raise an interrupt. The data lines leave the block as separate output, output-enable and input vectors, so the pad ring builds the bidirectional pins. The serial clock runs at half the core clock and idles low.

Top module: `flash_microseq`

## Requirements
- R1: A trigger accepted while idle takes the sequence number from bits 31:24 and the byte count from bits 23:0. The sequence number appears on `tbl_sel` and `busy` is high from the next clock. The table words are captured at the end of that clock.
- R2: An instruction has its opcode in bits 15:10, its line code in bits 9:8 and its operand in bits 7:0. Word k carries slot 2k in bits 15:0 and slot 2k+1 in bits 31:16. Slots run in order from 0.
- R3: Opcodes 1 (command), 2 (address) and 4 (mode) shift their operand byte out most significant bit first. Line code 0 uses 1 line, line code 1 uses 2 lines and line code 2 uses 4 lines, for 8, 4 or 2 serial clocks. In each clock the higher bits sit on the higher-numbered lines. A single line drives line 0. `io_oe` is set only on the driven lines.
- R4: Opcode 3 (dummy) gives as many serial clocks as its operand, with all lines released. An operand above 64 gives 64 clocks. An operand of 0 gives no clocks.
- R5: Opcode 8 (write) sends the trigger's byte count of bytes from `tx_data`, each laid out as in R3. `tx_next` pulses once for every byte taken.
- R6: Opcode 7 (read) releases all lines and samples them on each rising serial clock edge. A single line samples line 1, two lines sample lines 1:0 and four lines sample lines 3:0, most significant bit first. Each full byte is shown on `rx_data` with a one-clock `rx_valid` pulse.
- R7: A read or write step with a byte count of 0 is skipped and gives no serial clocks.
- R8: Opcode 0 ends the program. Every undefined opcode also ends it. With no ending opcode, the program ends after slot 7.
- R9: `cs_n` is low from the first instruction until the end of the program. `sck` pulses only while `cs_n` is low. `cs_n` is high on the clock in which `busy` drops and on the clock after each trigger.
- R10: A trigger that arrives while `busy` is high is ignored.
- R11: `done_flag` is set on the clock in which `busy` drops. A `flag_clr` pulse clears it. If a clear and a completion fall in the same clock, the flag ends up set.
- R12: `irq` is high exactly while both `done_flag` and `irq_en` are high.
- R13: During reset, `cs_n` is high, and `sck`, `io_oe`, `busy`, `done_flag`, `irq`, `rx_valid` and `tx_next` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_valid | input | 1 | Trigger strobe |
| start_word | input | 32 | Sequence number (31:24) and byte count (23:0) |
| tbl_sel | output | 8 | Sequence number presented to the table |
| tbl_data | input | 128 | Four program words for `tbl_sel`; word k in bits 32k+31:32k |
| tx_data | input | 8 | Next byte to write |
| tx_next | output | 1 | Pulse: the byte on `tx_data` was taken |
| rx_data | output | 8 | Last byte read |
| rx_valid | output | 1 | Pulse: `rx_data` holds a new byte |
| flag_clr | input | 1 | Write-one-to-clear for the completion flag |
| irq_en | input | 1 | Interrupt enable |
| done_flag | output | 1 | Sticky completion flag |
| irq | output | 1 | Interrupt request |
| busy | output | 1 | A program is running |
| sck | output | 1 | Serial clock |
| cs_n | output | 1 | Flash select, active low |
| io_out | output | 4 | Data line output values |
| io_oe | output | 4 | Data line output enables |
| io_in | input | 4 | Data line input values |

## Verification
A program can finish on the same clock that software writes a clear to the completion flag. The bench provokes this by holding `flag_clr` high across a whole transaction. The flag must read 1 on the clock in which `busy` falls, and 0 one clock later. A trigger can also arrive while a program is still shifting. The bench injects a second trigger with a different sequence number and byte count a few clocks into a run. It then checks that `tbl_sel`, the serial clock count and the received byte count all match the first trigger alone.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  localparam int WORD_W    = 32;
  localparam int WORDS     = 4;
  localparam int SLOTS     = WORDS * 2;
  localparam int SLOT_W    = $clog2(SLOTS);
  localparam int INSTR_W   = 16;
  localparam int DUMMY_MAX = 64;
  localparam int CNT_W     = $clog2(DUMMY_MAX + 1);
  localparam int IDX_HI    = 31;
  localparam int IDX_LO    = 24;
  localparam int IDX_W     = IDX_HI - IDX_LO + 1;
  localparam int LEN_W     = IDX_LO;
  localparam int LINES     = 4;

  localparam logic [5:0] OP_STOP  = 6'd0;
  localparam logic [5:0] OP_CMD   = 6'd1;
  localparam logic [5:0] OP_ADDR  = 6'd2;
  localparam logic [5:0] OP_DUMMY = 6'd3;
  localparam logic [5:0] OP_MODE  = 6'd4;
  localparam logic [5:0] OP_READ  = 6'd7;
  localparam logic [5:0] OP_WRITE = 6'd8;

  typedef struct packed {
    logic [5:0] op;
    logic [1:0] lane;
    logic [7:0] arg;
  } instr_t;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_DECODE, S_SHIFT, S_END
  } seq_st_e;

  function automatic logic [CNT_W-1:0] byte_clks(input logic [1:0] code);
    case (code)
      2'd0:    return CNT_W'(8);
      2'd1:    return CNT_W'(4);
      default: return CNT_W'(2);
    endcase
  endfunction

  function automatic logic [LINES-1:0] lane_mask(input logic [1:0] code);
    case (code)
      2'd0:    return 4'b0001;
      2'd1:    return 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction

  function automatic logic drives_lines(input logic [5:0] op);
    return (op == OP_CMD) || (op == OP_ADDR) || (op == OP_MODE) || (op == OP_WRITE);
  endfunction

endpackage

// File: rtl/seq_slot_pick.sv
module seq_slot_pick
  import flash_seq_pkg::*;
(
  input  logic [WORDS*WORD_W-1:0] words,
  input  logic [SLOT_W-1:0]       slot,
  output instr_t                  instr
);

  logic [INSTR_W-1:0] halves [SLOTS];

  for (genvar g = 0; g < SLOTS; g++) begin : g_half
    assign halves[g] = words[g*INSTR_W +: INSTR_W];
  end

  assign instr = instr_t'(halves[slot]);

endmodule

// File: rtl/seq_lane_shifter.sv
module seq_lane_shifter
  import flash_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [7:0]       load_byte,
  input  logic             shift_en,
  input  logic             sample_en,
  input  logic [1:0]       lane,
  input  logic [LINES-1:0] io_in,
  output logic [7:0]       sh_q,
  output logic [LINES-1:0] drive_bits
);

  logic [7:0] sh_d;

  always_comb begin
    sh_d = sh_q;
    if (load_en) begin
      sh_d = load_byte;
    end else if (sample_en) begin
      case (lane)
        2'd0:    sh_d = {sh_q[6:0], io_in[1]};
        2'd1:    sh_d = {sh_q[5:0], io_in[1:0]};
        default: sh_d = {sh_q[3:0], io_in[3:0]};
      endcase
    end else if (shift_en) begin
      case (lane)
        2'd0:    sh_d = {sh_q[6:0], 1'b0};
        2'd1:    sh_d = {sh_q[5:0], 2'b00};
        default: sh_d = {sh_q[3:0], 4'b0000};
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  always_comb begin
    case (lane)
      2'd0:    drive_bits = {3'b000, sh_q[7]};
      2'd1:    drive_bits = {2'b00, sh_q[7:6]};
      default: drive_bits = sh_q[7:4];
    endcase
  end

endmodule

// File: rtl/seq_flag.sv
module seq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  input  logic en,
  output logic flag,
  output logic irq
);

  logic flag_d;

  always_comb flag_d = set | (flag & ~clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= flag_d;
  end

  assign irq = flag & en;

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> flag); // R11
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && clr && !set) |=> !flag); // R11
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (en && flag)); // R12

endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import flash_seq_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_valid,
  input  logic [WORD_W-1:0]       start_word,
  input  logic [WORDS*WORD_W-1:0] tbl_data,
  input  instr_t                  cur,
  input  logic [7:0]              tx_data,
  input  logic [7:0]              sh_q,
  output logic [IDX_W-1:0]        tbl_sel,
  output logic [WORDS*WORD_W-1:0] words,
  output logic [SLOT_W-1:0]       slot,
  output logic                    load_en,
  output logic [7:0]              load_byte,
  output logic                    shift_en,
  output logic                    sample_en,
  output logic [1:0]              lane,
  output logic [LINES-1:0]        oe,
  output logic                    busy,
  output logic                    cs_n,
  output logic                    sck,
  output logic                    tx_next,
  output logic                    rx_valid,
  output logic [7:0]              rx_data,
  output logic                    done_set
);

  seq_st_e            st_q, st_d;
  logic [SLOT_W-1:0]  slot_d;
  logic [IDX_W-1:0]   idx_d;
  logic [LEN_W-1:0]   len_q, len_d;
  logic [LEN_W-1:0]   bleft_q, bleft_d;
  logic [CNT_W-1:0]   cleft_q, cleft_d;
  logic               ph_q, ph_d;
  logic [5:0]         op_q, op_d;
  logic [1:0]         lane_d;
  logic               words_en, take, push, adv;

  always_comb begin
    st_d      = st_q;
    slot_d    = slot;
    idx_d     = tbl_sel;
    len_d     = len_q;
    bleft_d   = bleft_q;
    cleft_d   = cleft_q;
    ph_d      = ph_q;
    op_d      = op_q;
    lane_d    = lane;
    words_en  = 1'b0;
    load_en   = 1'b0;
    load_byte = cur.arg;
    shift_en  = 1'b0;
    sample_en = 1'b0;
    take      = 1'b0;
    push      = 1'b0;
    adv       = 1'b0;
    done_set  = 1'b0;
    case (st_q)
      S_IDLE: begin
        if (start_valid) begin
          idx_d = start_word[IDX_HI:IDX_LO];
          len_d = start_word[LEN_W-1:0];
          st_d  = S_FETCH;
        end
      end
      S_FETCH: begin
        words_en = 1'b1;
        slot_d   = '0;
        st_d     = S_DECODE;
      end
      S_DECODE: begin
        ph_d    = 1'b0;
        op_d    = cur.op;
        lane_d  = cur.lane;
        bleft_d = LEN_W'(1);
        cleft_d = byte_clks(cur.lane);
        case (cur.op)
          OP_CMD, OP_ADDR, OP_MODE: begin
            load_en = 1'b1;
            st_d    = S_SHIFT;
          end
          OP_DUMMY: begin
            if (cur.arg == 8'd0) begin
              adv = 1'b1;
            end else begin
              cleft_d = (cur.arg > 8'(DUMMY_MAX)) ? CNT_W'(DUMMY_MAX) : cur.arg[CNT_W-1:0];
              st_d    = S_SHIFT;
            end
          end
          OP_READ: begin
            if (len_q == '0) begin
              adv = 1'b1;
            end else begin
              bleft_d = len_q;
              st_d    = S_SHIFT;
            end
          end
          OP_WRITE: begin
            if (len_q == '0) begin
              adv = 1'b1;
            end else begin
              bleft_d   = len_q;
              load_en   = 1'b1;
              load_byte = tx_data;
              take      = 1'b1;
              st_d      = S_SHIFT;
            end
          end
          default: st_d = S_END;
        endcase
      end
      S_SHIFT: begin
        if (!ph_q) begin
          ph_d      = 1'b1;
          sample_en = (op_q == OP_READ);
        end else begin
          ph_d     = 1'b0;
          shift_en = drives_lines(op_q);
          if (cleft_q == CNT_W'(1)) begin
            push = (op_q == OP_READ);
            if (bleft_q == LEN_W'(1)) begin
              adv = 1'b1;
            end else begin
              bleft_d = bleft_q - LEN_W'(1);
              cleft_d = byte_clks(lane);
              if (op_q == OP_WRITE) begin
                load_en   = 1'b1;
                load_byte = tx_data;
                take      = 1'b1;
              end
            end
          end else begin
            cleft_d = cleft_q - CNT_W'(1);
          end
        end
      end
      S_END: begin
        done_set = 1'b1;
        st_d     = S_IDLE;
      end
      default: st_d = S_IDLE;
    endcase
    if (adv) begin
      if (slot == SLOT_W'(SLOTS - 1)) begin
        st_d = S_END;
      end else begin
        slot_d = slot + SLOT_W'(1);
        st_d   = S_DECODE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= S_IDLE;
      slot     <= '0;
      tbl_sel  <= '0;
      len_q    <= '0;
      bleft_q  <= '0;
      cleft_q  <= '0;
      ph_q     <= 1'b0;
      op_q     <= OP_STOP;
      lane     <= 2'd0;
      cs_n     <= 1'b1;
      sck      <= 1'b0;
      tx_next  <= 1'b0;
      rx_valid <= 1'b0;
    end else begin
      st_q     <= st_d;
      slot     <= slot_d;
      tbl_sel  <= idx_d;
      len_q    <= len_d;
      bleft_q  <= bleft_d;
      cleft_q  <= cleft_d;
      ph_q     <= ph_d;
      op_q     <= op_d;
      lane     <= lane_d;
      cs_n     <= !((st_d == S_DECODE) || (st_d == S_SHIFT));
      sck      <= (st_d == S_SHIFT) && ph_d;
      tx_next  <= take;
      rx_valid <= push;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        words <= '0;
    else if (words_en) words <= tbl_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rx_data <= '0;
    else if (push) rx_data <= sh_q;
  end

  assign busy = (st_q != S_IDLE);
  assign oe   = ((st_q == S_SHIFT) && drives_lines(op_q)) ? lane_mask(lane) : '0;

  AST_CS_HIGH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> cs_n); // R9
  AST_SCK_IN_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    sck |-> !cs_n); // R9
  AST_FETCH_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> cs_n); // R9
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start_valid) |=> $stable(tbl_sel)); // R10
  AST_DUMMY_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    cleft_q <= CNT_W'(DUMMY_MAX)); // R4
  AST_RX_LINES_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (oe == '0)); // R6

endmodule

// File: rtl/flash_microseq.sv
module flash_microseq
  import flash_seq_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_valid,
  input  logic [31:0]  start_word,
  output logic [7:0]   tbl_sel,
  input  logic [127:0] tbl_data,
  input  logic [7:0]   tx_data,
  output logic         tx_next,
  output logic [7:0]   rx_data,
  output logic         rx_valid,
  input  logic         flag_clr,
  input  logic         irq_en,
  output logic         done_flag,
  output logic         irq,
  output logic         busy,
  output logic         sck,
  output logic         cs_n,
  output logic [3:0]   io_out,
  output logic [3:0]   io_oe,
  input  logic [3:0]   io_in
);

  logic rst_s1, rst_s2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  logic [WORDS*WORD_W-1:0] words;
  logic [SLOT_W-1:0]       slot;
  instr_t                  cur;
  logic                    load_en, shift_en, sample_en, done_set;
  logic [7:0]              load_byte, sh_q;
  logic [1:0]              lane;
  logic [LINES-1:0]        drive_bits, oe;

  seq_slot_pick u_pick (
    .words (words),
    .slot  (slot),
    .instr (cur)
  );

  seq_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_s2),
    .start_valid (start_valid),
    .start_word  (start_word),
    .tbl_data    (tbl_data),
    .cur         (cur),
    .tx_data     (tx_data),
    .sh_q        (sh_q),
    .tbl_sel     (tbl_sel),
    .words       (words),
    .slot        (slot),
    .load_en     (load_en),
    .load_byte   (load_byte),
    .shift_en    (shift_en),
    .sample_en   (sample_en),
    .lane        (lane),
    .oe          (oe),
    .busy        (busy),
    .cs_n        (cs_n),
    .sck         (sck),
    .tx_next     (tx_next),
    .rx_valid    (rx_valid),
    .rx_data     (rx_data),
    .done_set    (done_set)
  );

  seq_lane_shifter u_shift (
    .clk        (clk),
    .rst_n      (rst_s2),
    .load_en    (load_en),
    .load_byte  (load_byte),
    .shift_en   (shift_en),
    .sample_en  (sample_en),
    .lane       (lane),
    .io_in      (io_in),
    .sh_q       (sh_q),
    .drive_bits (drive_bits)
  );

  seq_flag u_flag (
    .clk   (clk),
    .rst_n (rst_s2),
    .set   (done_set),
    .clr   (flag_clr),
    .en    (irq_en),
    .flag  (done_flag),
    .irq   (irq)
  );

  assign io_oe  = oe;
  assign io_out = drive_bits & oe;

  AST_OE_ONLY_SELECTED: assert property (@(posedge clk) disable iff (!rst_s2)
    (io_oe != 4'b0000) |-> !cs_n); // R3
  AST_DONE_AT_FINISH: assert property (@(posedge clk) disable iff (!rst_s2)
    $fell(busy) |-> done_flag); // R11

endmodule

// File: tb/tb_flash_microseq.sv
module tb_flash_microseq;

  typedef struct packed {
    logic [127:0] words;
    logic [23:0]  len;
    logic [3:0]   pins;
    logic [7:0]   clks;
    logic [7:0]   bits;
    logic [31:0]  dout;
    logic [7:0]   nrx;
    logic [7:0]   lastrx;
  } vec_t;

  // words = {w3, w2, w1, w0}; instruction = op<<10 | lane<<8 | operand
  localparam vec_t VT [8] = '{
    // R2 R3 R6: 1-line command 9F, 1-line read of 2 bytes (line 1 high)
    '{128'h00000000_00000000_00000000_1C00049F, 24'd2, 4'h2, 8'd24, 8'd8,  32'h0000009F, 8'd2, 8'hFF},
    // R3 R4 R6: cmd EB, 4-line addr 12 34, mode A5, 4 dummy, 4-line read x3
    '{128'h00000000_1E000E04_12A50A34_0A1204EB, 24'd3, 4'hA, 8'd24, 8'd32, 32'hEB1234A5, 8'd3, 8'hAA},
    // R5: cmd 02, addr 80, 2-line write of C0 C1
    '{128'h00000000_00000000_00002100_08800402, 24'd2, 4'h0, 8'd24, 8'd32, 32'h0280C0C1, 8'd0, 8'h00},
    // R8: eight 4-line commands 11..88, no stop
    '{128'h06880677_06660655_06440633_06220611, 24'd0, 4'h0, 8'd16, 8'd64, 32'h55667788, 8'd0, 8'h00},
    // R7 R4: zero dummy, zero-length read and write are skipped
    '{128'h00000000_00000000_20001D00_0C000405, 24'd0, 4'hF, 8'd8,  8'd8,  32'h00000005, 8'd0, 8'h00},
    // R4: dummy operand 100 clamps to 64
    '{128'h00000000_00000000_00000000_0C640401, 24'd0, 4'h0, 8'd72, 8'd8,  32'h00000001, 8'd0, 8'h00},
    // R8: undefined opcode 5 ends the program
    '{128'h00000000_00000000_00000477_14000466, 24'd0, 4'h0, 8'd8,  8'd8,  32'h00000066, 8'd0, 8'h00},
    // R3 R6: 2-line cmd 3B, 2-line read of 1 byte
    '{128'h00000000_00000000_00000000_1D00053B, 24'd1, 4'h1, 8'd8,  8'd8,  32'h0000003B, 8'd1, 8'h55}
  };

  logic         clk = 1'b0;
  logic         rst_n;
  logic         start_valid;
  logic [31:0]  start_word;
  logic [7:0]   tbl_sel;
  logic [127:0] tbl_data;
  logic [7:0]   tx_data;
  logic         tx_next;
  logic [7:0]   rx_data;
  logic         rx_valid;
  logic         flag_clr;
  logic         irq_en;
  logic         done_flag;
  logic         irq;
  logic         busy;
  logic         sck;
  logic         cs_n;
  logic [3:0]   io_out;
  logic [3:0]   io_oe;
  logic [3:0]   io_in;

  always #5 clk = ~clk;

  flash_microseq dut (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_word(start_word),
    .tbl_sel(tbl_sel), .tbl_data(tbl_data), .tx_data(tx_data), .tx_next(tx_next),
    .rx_data(rx_data), .rx_valid(rx_valid), .flag_clr(flag_clr), .irq_en(irq_en),
    .done_flag(done_flag), .irq(irq), .busy(busy), .sck(sck), .cs_n(cs_n),
    .io_out(io_out), .io_oe(io_oe), .io_in(io_in)
  );

  int checks = 0;
  int errors = 0;

  int          mon_clks = 0;
  int          mon_bits = 0;
  int          mon_rx = 0;
  int          mon_cs_err = 0;
  int          tx_idx = 0;
  logic [63:0] mon_acc = '0;
  logic [7:0]  mon_rx_last = '0;
  logic [3:0]  tx_base = '0;

  assign tx_data = {4'hC, 4'(tx_idx) - tx_base};

  always @(negedge clk) begin
    if (sck) begin
      mon_clks++;
      if (cs_n) mon_cs_err++;
      case (io_oe)
        4'b0001: begin mon_acc = {mon_acc[62:0], io_out[0]};   mon_bits += 1; end
        4'b0011: begin mon_acc = {mon_acc[61:0], io_out[1:0]}; mon_bits += 2; end
        4'b1111: begin mon_acc = {mon_acc[59:0], io_out[3:0]}; mon_bits += 4; end
        default: ;
      endcase
    end
    if (rx_valid) begin
      mon_rx++;
      mon_rx_last = rx_data;
    end
    if (tx_next) tx_idx++;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_seq(input logic [7:0] idx, input vec_t v, input bit inject, input string tag);
    int b_clks, b_bits, b_rx, nb, n;
    logic [31:0] m;
    b_clks   = mon_clks;
    b_bits   = mon_bits;
    b_rx     = mon_rx;
    tx_base  = 4'(tx_idx);
    tbl_data = v.words;
    io_in    = v.pins;
    @(negedge clk);
    start_valid = 1'b1;
    start_word  = {idx, v.len};
    @(negedge clk);
    start_valid = 1'b0;
    chk(busy && tbl_sel == idx, {"R1 start accepted ", tag}, {busy, tbl_sel}, {1'b1, idx});
    if (inject) begin
      repeat (5) @(negedge clk);
      start_valid = 1'b1;
      start_word  = 32'h7E00_0009;
      @(negedge clk);
      start_valid = 1'b0;
    end
    n = 0;
    while (busy && n < 3000) begin
      @(negedge clk);
      n++;
    end
    chk(!busy, {"R8 program ends ", tag}, busy, 0);
    nb = mon_bits - b_bits;
    m  = (nb >= 32) ? 32'hFFFF_FFFF : ((32'h1 << nb) - 32'h1);
    chk((mon_clks - b_clks) == int'(v.clks), {"R3 serial clock count ", tag}, mon_clks - b_clks, v.clks);
    chk(nb == int'(v.bits), {"R3 driven bit count ", tag}, nb, v.bits);
    chk((mon_acc[31:0] & m) == v.dout, {"R3 driven data ", tag}, mon_acc[31:0] & m, v.dout);
    chk((mon_rx - b_rx) == int'(v.nrx), {"R6 read byte count ", tag}, mon_rx - b_rx, v.nrx);
    if (v.nrx != 0)
      chk(mon_rx_last == v.lastrx, {"R6 read data ", tag}, mon_rx_last, v.lastrx);
    chk(cs_n && !sck, {"R9 select released ", tag}, {cs_n, sck}, 2'b10);
    chk(done_flag, {"R11 flag set at finish ", tag}, done_flag, 1);
    if (inject)
      chk(tbl_sel == idx, "R10 index kept", tbl_sel, idx);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R8 watchdog actual=running expected=finished");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    string vtag [8];
    vtag = '{"R2 R6 v0 single", "R4 R6 v1 quad", "R5 v2 dual write", "R8 v3 no stop",
             "R7 v4 skips", "R4 v5 dummy clamp", "R8 v6 bad opcode", "R6 v7 dual read"};
    rst_n       = 1'b0;
    start_valid = 1'b0;
    start_word  = '0;
    tbl_data    = '0;
    flag_clr    = 1'b0;
    irq_en      = 1'b0;
    io_in       = '0;
    repeat (3) @(negedge clk);
    chk(cs_n && !sck && io_oe == 0 && !busy && !done_flag && !irq && !rx_valid && !tx_next,
        "R13 reset state", {cs_n, sck, io_oe, busy, done_flag, irq, rx_valid, tx_next}, 11'h400);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(cs_n && !busy, "R13 idle after reset", {cs_n, busy}, 2'b10);

    for (int i = 0; i < 8; i++) run_seq(8'(i + 1), VT[i], 1'b0, vtag[i]);
    chk(mon_cs_err == 0, "R9 clock only while selected", mon_cs_err, 0);

    chk(!irq, "R12 irq masked", irq, 0);
    @(negedge clk);
    irq_en = 1'b1;
    @(negedge clk);
    chk(irq, "R12 irq enabled", irq, 1);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    chk(!done_flag && !irq, "R11 flag cleared", {done_flag, irq}, 0);

    run_seq(8'h03, VT[0], 1'b1, "R10 trigger while busy");

    flag_clr = 1'b1;
    run_seq(8'h05, VT[7], 1'b0, "R11 clear at finish");
    chk(irq, "R12 irq with set-wins flag", irq, 1);
    @(negedge clk);
    chk(!done_flag, "R11 clear after finish", done_flag, 0);
    flag_clr = 1'b0;
    chk(mon_cs_err == 0, "R9 clock only while selected final", mon_cs_err, 0);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule